// File: doc/BRIEF.md
# Oscillator Calibration Cycle Counter

This block measures a slow or untrimmed oscillator against the fast, crystal-derived system clock. Software picks one of four oscillator inputs and loads a window length, counted in cycles of that oscillator. It then sets a start bit. The block opens a gate that lasts exactly that many oscillator cycles. While the gate is open, it counts system-clock cycles into a 32-bit accumulator. When the gate closes, the count is copied into two 16-bit read-only halves and the start bit drops. From the window length and the count, software can work out the oscillator frequency and use it to trim the oscillator.

The window itself runs in the selected oscillator's clock domain. A toggle request crosses into that domain through a two-flop synchronizer. The gate crosses back through a second synchronizer. A system-domain state machine has four states:

- `ST_IDLE`: waits for a start request. It goes to `ST_ARM` when a start is accepted.
- `ST_ARM`: waits for the synchronized gate to rise. It goes to `ST_MEASURE` when it does.
- `ST_MEASURE`: counts while the gate is high. It goes to `ST_LATCH` when the synchronized gate falls.
- `ST_LATCH`: copies the count into the result register. It always returns to `ST_IDLE` on the next cycle, and the start bit clears at that same edge.

Top module: `osc_cal_counter`

## Requirements
- R1: After reset, every register reads 0: control, window, result low and result high.
- R2: Register map, by byte address: 0 is control, 2 is window length, 4 is result bits [15:0], and 6 is result bits [31:16]. Any other address reads 0. The window register reads back the value written to it.
- R3: Control bit 2 is the start bit. Writing 1 to it while idle starts a calibration. Bit 2 then reads 1 until the calibration ends and the result is valid, and it then reads 0.
- R4: Control bits [1:0] select the oscillator input: 0 is the slow RC oscillator, 1 is the fast RC oscillator, 2 is the 32 kHz crystal oscillator, and 3 is the RCX oscillator. The window is timed by the selected input.
- R5: The result equals the number of system-clock cycles in a window of N cycles of the selected oscillator, within ±2 of N·Tosc/Tsys.
- R6: A window length of 0 behaves exactly like a window length of 1.
- R7: The result is 32 bits wide, split across the low and high registers. It changes only at the edge where the start bit clears.
- R8: While a calibration is in progress, writes to the select field, the window register or the start bit are ignored.
- R9: Accepting a new start clears the accumulator, so each result counts only its own window.
- R10: A new start written right after the previous calibration ends is accepted and completes. The latch state always returns to idle one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, derived from the crystal |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_clk_i | input | 4 | Oscillator clocks that can be measured, indexed by the select field |
| addr_i | input | 3 | Register byte address |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge of clk_i |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, decoded from addr_i |

## Verification
The bench steps through every select code, using clocks with distinct period ratios, so a wrong clock index produces a count off by a whole factor. A window of 0 is checked against the one-cycle result; a design that loaded 0 directly would either hang or count 65536 cycles. One long window pushes the count past 16 bits, which exposes a truncated accumulator or swapped halves. Writes made during a calibration must leave the window, select and result untouched, and a calibration started immediately after the previous one must report a fresh count. A design that kept accumulating across runs, or missed the second start, fails those checks.

// File: rtl/osccal_pkg.sv
package osccal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARM     = 2'd1,
        ST_MEASURE = 2'd2,
        ST_LATCH   = 2'd3
    } cal_state_e;

    localparam int unsigned OFS_CTRL   = 0;
    localparam int unsigned OFS_WIN    = 2;
    localparam int unsigned OFS_RES_LO = 4;
    localparam int unsigned OFS_RES_HI = 6;
    localparam int unsigned START_BIT  = 2;
endpackage

// File: rtl/osccal_sync.sv
module osccal_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/osccal_window.sv
// Runs in the selected oscillator's domain. A change of the request toggle
// opens the gate for win_len oscillator cycles (a length of 0 counts as 1).
module osccal_window #(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic             req_tgl,
    input  logic [CNT_W-1:0] win_len,
    output logic             gate
);
    logic             req_s;
    logic             req_seen;
    logic [CNT_W-1:0] remain;

    osccal_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (osc_clk),
        .rst_n (rst_n),
        .d     (req_tgl),
        .q     (req_s)
    );

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            req_seen <= 1'b0;
            remain   <= '0;
            gate     <= 1'b0;
        end else if (gate) begin
            if (remain <= CNT_W'(1)) gate   <= 1'b0;
            else                     remain <= remain - CNT_W'(1);
        end else if (req_s != req_seen) begin
            req_seen <= req_s;
            gate     <= 1'b1;
            remain   <= (win_len == '0) ? CNT_W'(1) : win_len;
        end
    end
endmodule

// File: rtl/osccal_accum.sv
module osccal_accum #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  value <= '0;
        else if (clr) value <= '0;
        else if (en)  value <= value + W'(1);
    end
endmodule

// File: rtl/osc_cal_counter.sv
module osc_cal_counter
    import osccal_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned N_OSC       = 4,
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_OSC-1:0]  osc_clk_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int unsigned SEL_W = $clog2(N_OSC);
    localparam int unsigned ACC_W = 2 * DATA_W;

    cal_state_e        state_q, state_d;
    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] win_q;
    logic [ACC_W-1:0]  res_q;
    logic [ACC_W-1:0]  acc_val;
    logic              req_tgl_q;
    logic              osc_clk_sel;
    logic              gate_osc, gate_s;
    logic              busy, acc_en, res_load;
    logic              wr_ctrl, wr_win, start_fire;

    // register write decode
    assign wr_ctrl    = wr_en_i && (addr_i == ADDR_W'(OFS_CTRL));
    assign wr_win     = wr_en_i && (addr_i == ADDR_W'(OFS_WIN));
    assign start_fire = wr_ctrl && wdata_i[START_BIT] && (state_q == ST_IDLE);

    // oscillator selection, held still for the whole calibration
    assign osc_clk_sel = osc_clk_i[sel_q];

    osccal_window #(.CNT_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_window (
        .osc_clk (osc_clk_sel),
        .rst_n   (rst_ni),
        .req_tgl (req_tgl_q),
        .win_len (win_q),
        .gate    (gate_osc)
    );

    osccal_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk   (clk_i),
        .rst_n (rst_ni),
        .d     (gate_osc),
        .q     (gate_s)
    );

    osccal_accum #(.W(ACC_W)) u_accum (
        .clk   (clk_i),
        .rst_n (rst_ni),
        .clr   (start_fire),
        .en    (acc_en),
        .value (acc_val)
    );

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_fire) state_d = ST_ARM;
            ST_ARM:     if (gate_s)     state_d = ST_MEASURE;
            ST_MEASURE: if (!gate_s)    state_d = ST_LATCH;
            ST_LATCH:                   state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        busy     = 1'b1;
        acc_en   = 1'b0;
        res_load = 1'b0;
        unique case (state_q)
            ST_IDLE:    busy     = 1'b0;
            ST_ARM:     acc_en   = gate_s;
            ST_MEASURE: acc_en   = gate_s;
            ST_LATCH:   res_load = 1'b1;
            default:    busy     = 1'b0;
        endcase
    end

    // software-visible registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sel_q     <= '0;
            win_q     <= '0;
            res_q     <= '0;
            req_tgl_q <= 1'b0;
        end else begin
            if (wr_ctrl && !busy) sel_q <= wdata_i[SEL_W-1:0];
            if (wr_win && !busy)  win_q <= wdata_i;
            if (start_fire)       req_tgl_q <= ~req_tgl_q;
            if (res_load)         res_q <= acc_val;
        end
    end

    // read mux
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(OFS_CTRL)) begin
            rdata_o[SEL_W-1:0] = sel_q;
            rdata_o[START_BIT] = busy;
        end else if (addr_i == ADDR_W'(OFS_WIN)) begin
            rdata_o = win_q;
        end else if (addr_i == ADDR_W'(OFS_RES_LO)) begin
            rdata_o = res_q[DATA_W-1:0];
        end else if (addr_i == ADDR_W'(OFS_RES_HI)) begin
            rdata_o = res_q[ACC_W-1:DATA_W];
        end
    end
endmodule

// File: rtl/osccal_checker.sv
module osccal_checker
    import osccal_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned SEL_W  = 2,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned ACC_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              start_bit,
    input logic              busy,
    input logic [SEL_W-1:0]  sel_q,
    input logic [DATA_W-1:0] win_q,
    input logic [ACC_W-1:0]  res_q,
    input logic              gate_s,
    input cal_state_e        state
);
    assert_start_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && addr == ADDR_W'(OFS_CTRL) && start_bit) |=> busy);

    assert_win_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && addr == ADDR_W'(OFS_WIN)) |=> $stable(win_q));

    assert_sel_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && addr == ADDR_W'(OFS_CTRL)) |=> $stable(sel_q));

    assert_result_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_q) |-> $fell(busy));

    assert_latch_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCH) |=> (state == ST_IDLE));

    assert_arm_waits_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM && !gate_s) |=> (state == ST_ARM));
endmodule

bind osc_cal_counter osccal_checker #(
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W),
    .ADDR_W (ADDR_W),
    .ACC_W  (ACC_W)
) u_chk (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .wr_en     (wr_en_i),
    .addr      (addr_i),
    .start_bit (wdata_i[osccal_pkg::START_BIT]),
    .busy      (busy),
    .sel_q     (sel_q),
    .win_q     (win_q),
    .res_q     (res_q),
    .gate_s    (gate_s),
    .state     (state_q)
);

// File: tb/tb_osc_cal_counter.sv
module tb_osc_cal_counter;
    localparam int SYS_PERIOD = 10;
    localparam int OSC_HALF [4] = '{85, 15, 65, 35};
    localparam int NV = 6;
    // select, window, expected system cycles
    localparam int V_SEL [NV] = '{0, 1, 2, 3, 1, 3};
    localparam int V_WIN [NV] = '{10, 1, 40, 100, 0, 7};
    localparam int V_EXP [NV] = '{170, 3, 520, 700, 3, 49};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  osc = 4'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    int checks = 0;
    int fails = 0;

    osc_cal_counter dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .osc_clk_i (osc),
        .addr_i    (addr),
        .wr_en_i   (wr_en),
        .wdata_i   (wdata),
        .rdata_o   (rdata)
    );

    always #(SYS_PERIOD/2) clk = ~clk;

    for (genvar g = 0; g < 4; g++) begin : g_osc
        initial begin
            #3;
            forever #(OSC_HALF[g]) osc[g] = ~osc[g];
        end
    end

    task automatic check(input string tag, input int act, input int exp, input int tol);
        checks++;
        if (act < exp - tol || act > exp + tol) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (tol %0d)", tag, act, exp, tol);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_done();
        logic [15:0] c;
        do bus_read(3'd0, c); while (c[2]);
    endtask

    task automatic read_result(output int res);
        logic [15:0] lo, hi;
        bus_read(3'd4, lo);
        bus_read(3'd6, hi);
        res = int'({hi, lo});
    endtask

    task automatic run_cal(input int sel, input int win, output int res);
        logic [15:0] c;
        bus_write(3'd2, 16'(win));
        bus_write(3'd0, 16'(4 + sel));
        bus_read(3'd0, c);
        check("R3 start bit reads 1 while busy", int'(c[2]), 1, 0);
        wait_done();
        read_result(res);
    endtask

    initial begin
        #(SYS_PERIOD * 180000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int res;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 8; a += 2) begin
            bus_read(3'(a), d);
            check("R1 reset register value", int'(d), 0, 0);
        end

        // table walk: R4 select codes, R5 counts, R6 zero window
        for (int i = 0; i < NV; i++) begin
            run_cal(V_SEL[i], V_WIN[i], res);
            check(V_WIN[i] == 0 ? "R6 zero window as one" : "R5/R4 count for select",
                  res, V_EXP[i], 2);
            bus_read(3'd0, d);
            check("R4 select readback", int'(d[1:0]), V_SEL[i], 0);
        end

        // R7: count above 16 bits, 3900 * 17 = 66300
        run_cal(0, 3900, res);
        check("R7 32-bit result", res, 66300, 2);
        bus_read(3'd6, d);
        check("R7 high half", int'(d), 1, 0);

        // R8: writes during a calibration are ignored
        bus_write(3'd2, 16'd20);
        bus_write(3'd0, 16'd4);
        bus_write(3'd2, 16'd500);
        bus_write(3'd0, 16'd7);
        wait_done();
        bus_read(3'd2, d);
        check("R8 window unchanged by busy write", int'(d), 20, 0);
        bus_read(3'd0, d);
        check("R8 select unchanged by busy write", int'(d), 0, 0);
        read_result(res);
        check("R8 result uses original window", res, 340, 2);

        // R9/R10: immediate restart gives a fresh count
        run_cal(1, 5, res);
        check("R9 accumulator cleared on restart", res, 15, 2);
        run_cal(3, 2, res);
        check("R10 back-to-back calibration", res, 14, 2);

        // R2: unused addresses and window readback
        bus_read(3'd1, d);
        check("R2 unused address 1 reads 0", int'(d), 0, 0);
        bus_read(3'd5, d);
        check("R2 unused address 5 reads 0", int'(d), 0, 0);
        bus_read(3'd2, d);
        check("R2 window readback", int'(d), 2, 0);

        // R1: reset again after activity
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 8; a += 2) begin
            bus_read(3'(a), d);
            check("R1 register after second reset", int'(d), 0, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule